// File: doc/BRIEF.md
# Polyphase Half-Band Interpolator by Two

This block raises the sample rate of a signed fixed-point stream by two. Each sample accepted at the input produces two output samples on consecutive clock cycles. Zeros are never inserted. Instead, the accepted sample enters a four-deep history, and two coefficient branches read that history in turn.

The filter is a seven-tap half-band low-pass. Its taps at positions 1 and 5 are zero, so the arithmetic skips them. The 2x gain that replaces the energy lost to upsampling is already built into the coefficient parameters.

- The even-phase branch uses the four outer taps. Symmetric taps are pre-added, so this branch needs only two multipliers.
- The odd-phase branch reduces to the doubled centre tap, whose value is exactly 1.0. That output is simply the previous sample taken from the history.

With the default coefficients (-1/16 on the outer pair, 9/16 on the inner pair), the coefficients of each branch sum to 1.0. A constant input or a slow tone therefore leaves the block at its full amplitude, not at half.

The input uses a valid/ready handshake. The output carries only a valid flag and cannot be stalled. The source may hold `in_valid` high at all times: `in_ready` drops for one cycle after each accept, so the block takes at most one sample every two cycles and emits one result every cycle. While `in_ready` is low, `in_data` is ignored.

Top module: `hbi_interp2`

## Requirements
- R1: During and after reset, `out_valid` is 0, `in_ready` is 1 and the sample history holds zeros. The first outputs after reset are therefore computed as though all earlier samples were zero.
- R2: A sample is taken on a rising edge where both `in_valid` and `in_ready` are 1. `in_ready` is 0 for exactly the one cycle after that edge and is 1 otherwise. `in_data` has no effect on any output while `in_ready` is 0.
- R3: For a sample accepted at edge k, `out_valid` is 1 after edge k+1, carrying the even-phase result, and again after edge k+2, carrying the odd-phase result.
- R4: `out_valid` is 0 in every cycle that holds no result due under R3.
- R5: The even-phase result for newest sample x0 and older samples x1, x2, x3 is computed as follows. First form S = C_OUTER*(x0+x3) + C_INNER*(x1+x2) at full precision. Then round S / 2^FRAC by adding 2^(FRAC-1) and taking the floor. For example, with the defaults, an input of -0.5 LSB becomes 0 and an input of +0.5 LSB becomes 1.
- R6: A rounded even-phase value above 2^(DW-1)-1 is output as 2^(DW-1)-1. A value below -2^(DW-1) is output as -2^(DW-1).
- R7: The odd-phase result equals x1, the sample accepted just before the newest one, bit for bit.
- R8: With the default coefficients, a constant input K produces K on both phases once four samples have been taken. A slow sine of peak 32767 comes out with a peak near 32767, not near half of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample at the next edge |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | `out_data` holds a new result this cycle |
| out_data | output | DW | Signed output sample at twice the input rate |

## Verification
Every result has a fixed due cycle relative to the edge that accepts its sample:

- `in_ready` is low one cycle after the accept.
- The even-phase value appears two falling edges later.
- The odd-phase value appears three falling edges later.

The bench stamps each value its reference model predicts with that due cycle. It samples on every falling edge and compares the front entry only when the cycle number matches. In any cycle with no entry due, it requires `out_valid` to be low. This catches an output that arrives early, late, twice or unprompted, as well as a wrong value.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  // Output phase pending in the controller.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EVEN = 2'd1,
    PH_ODD  = 2'd2
  } hbi_phase_e;

  // Depth of the sample history seen by the even-phase branch.
  localparam int HBI_HIST = 4;

  // Width of the full-precision even-phase sum.
  function automatic int hbi_acc_width(input int dw, input int cw);
    return dw + cw + 2;
  endfunction

endpackage

// File: rtl/hbi_phase_ctrl.sv
module hbi_phase_ctrl
  import hbi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic accept_o,
  output logic emit_even_o,
  output logic emit_odd_o
);

  hbi_phase_e phase_q;
  hbi_phase_e phase_d;

  // An accepted sample makes the even phase pending; the odd phase follows
  // unconditionally. A new sample may be taken on the odd-phase edge.
  assign in_ready_o  = (phase_q != PH_EVEN);
  assign accept_o    = in_valid_i && in_ready_o;
  assign emit_even_o = (phase_q == PH_EVEN);
  assign emit_odd_o  = (phase_q == PH_ODD);

  always_comb begin
    if (accept_o) begin
      phase_d = PH_EVEN;
    end else if (phase_q == PH_EVEN) begin
      phase_d = PH_ODD;
    end else begin
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/hbi_tap_line.sv
module hbi_tap_line #(
  parameter int DW   = 16,
  parameter int TAPS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_i,
  input  logic signed [DW-1:0] din_i,
  output logic signed [DW-1:0] taps_o [TAPS]
);

  // Element 0 holds the newest sample.
  for (genvar g = 0; g < TAPS; g++) begin : g_stage
    logic signed [DW-1:0] stage_q;

    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else if (shift_i) begin
          stage_q <= din_i;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else if (shift_i) begin
          stage_q <= g_stage[g-1].stage_q;
        end
      end
    end

    assign taps_o[g] = stage_q;
  end

endmodule

// File: rtl/hbi_branch_even.sv
module hbi_branch_even #(
  parameter int DW      = 16,
  parameter int CW      = 18,
  parameter int C_OUTER = -4096,
  parameter int C_INNER = 36864,
  localparam int PW     = DW + 1,
  localparam int MW     = PW + CW,
  localparam int AW     = MW + 1
) (
  input  logic signed [DW-1:0] taps_i [4],
  output logic signed [AW-1:0] acc_o
);

  localparam logic signed [CW-1:0] K_OUTER = CW'(C_OUTER);
  localparam logic signed [CW-1:0] K_INNER = CW'(C_INNER);

  logic signed [PW-1:0] pre_outer;
  logic signed [PW-1:0] pre_inner;
  logic signed [MW-1:0] prod_outer;
  logic signed [MW-1:0] prod_inner;

  // Mirror taps share one coefficient, so they are added before the multiply.
  assign pre_outer  = PW'(taps_i[0]) + PW'(taps_i[3]);
  assign pre_inner  = PW'(taps_i[1]) + PW'(taps_i[2]);
  assign prod_outer = MW'(pre_outer) * MW'(K_OUTER);
  assign prod_inner = MW'(pre_inner) * MW'(K_INNER);
  assign acc_o      = AW'(prod_outer) + AW'(prod_inner);

endmodule

// File: rtl/hbi_round_sat.sv
module hbi_round_sat #(
  parameter int IN_W  = 36,
  parameter int OUT_W = 16,
  parameter int FRAC  = 16
) (
  input  logic signed [IN_W-1:0]  acc_i,
  output logic signed [OUT_W-1:0] res_o
);

  localparam int SW = IN_W + 1;
  localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);
  localparam logic signed [SW-1:0] MAXV = SW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  logic signed [SW-1:0] biased;
  logic signed [SW-1:0] scaled;

  // Add half an LSB, then floor: ties go toward plus infinity.
  assign biased = SW'(acc_i) + HALF;
  assign scaled = biased >>> FRAC;

  always_comb begin
    if (scaled > MAXV) begin
      res_o = MAXV[OUT_W-1:0];
    end else if (scaled < MINV) begin
      res_o = MINV[OUT_W-1:0];
    end else begin
      res_o = scaled[OUT_W-1:0];
    end
  end

endmodule

// File: rtl/hbi_interp2.sv
module hbi_interp2
  import hbi_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CW      = 18,
  parameter int FRAC    = 16,
  parameter int C_OUTER = -4096,
  parameter int C_INNER = 36864
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  localparam int AW = hbi_acc_width(DW, CW);

  logic                 accept;
  logic                 emit_even;
  logic                 emit_odd;
  logic signed [DW-1:0] hist [HBI_HIST];
  logic signed [AW-1:0] even_acc;
  logic signed [DW-1:0] even_res;
  logic                 out_valid_q;
  logic [DW-1:0]        out_data_q;

  hbi_phase_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .accept_o    (accept),
    .emit_even_o (emit_even),
    .emit_odd_o  (emit_odd)
  );

  hbi_tap_line #(
    .DW   (DW),
    .TAPS (HBI_HIST)
  ) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (accept),
    .din_i   ($signed(in_data)),
    .taps_o  (hist)
  );

  hbi_branch_even #(
    .DW      (DW),
    .CW      (CW),
    .C_OUTER (C_OUTER),
    .C_INNER (C_INNER)
  ) u_even (
    .taps_i (hist),
    .acc_o  (even_acc)
  );

  hbi_round_sat #(
    .IN_W  (AW),
    .OUT_W (DW),
    .FRAC  (FRAC)
  ) u_rs (
    .acc_i (even_acc),
    .res_o (even_res)
  );

  // The odd phase is the doubled centre tap (1.0), so it is a plain read of
  // the second-newest history entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else if (emit_even) begin
      out_valid_q <= 1'b1;
      out_data_q  <= even_res;
    end else if (emit_odd) begin
      out_valid_q <= 1'b1;
      out_data_q  <= hist[1];
    end else begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

endmodule

// File: rtl/hbi_interp2_chk.sv
module hbi_interp2_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);

  logic          acc;
  logic [DW-1:0] cur_q;
  logic [DW-1:0] prev_q;

  assign acc = in_valid && in_ready;

  // Observer copy of the last two accepted samples, taken at the ports.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (acc) begin
      cur_q  <= in_data;
      prev_q <= cur_q;
    end
  end

  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready);

  p_ready_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  p_even_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ##1 out_valid);

  p_odd_due_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ##2 out_valid);

  p_odd_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ##2 (out_data == $past(prev_q, 1)));

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(acc, 2) || $past(acc, 3)));

endmodule

bind hbi_interp2 hbi_interp2_chk #(.DW(DW)) u_chk (.*);

// File: tb/hbi_interp2_tb_top.sv
`timescale 1ns/1ps
module hbi_interp2_tb_top;

  localparam int DW      = 16;
  localparam int FRAC    = 16;
  localparam int C_OUTER = -4096;
  localparam int C_INNER = 36864;
  localparam int MAXV    = 32767;
  localparam int MINV    = -32768;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  hbi_interp2 dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  typedef struct {
    int    due;
    int    val;
    string tag;
  } exp_t;

  exp_t  expq[$];
  int    hist[4];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    last_acc = 0;
  bit    done = 0;
  string seg_tag = "";
  bit    track = 0;
  int    peak = MINV;
  int    last_out = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp_v);
    end
  endtask

  function automatic int model_even();
    longint s;
    longint r;
    s = longint'(C_OUTER) * (hist[0] + hist[3]) + longint'(C_INNER) * (hist[1] + hist[2]);
    r = (s + (longint'(1) << (FRAC - 1))) >>> FRAC;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    return int'(r);
  endfunction

  function automatic int sample(input int mode, input int k);
    case (mode)
      0: return (k == 0) ? 1000 : 0;
      1: return 16384;
      2: return k * 97 - 3000;
      3: return (k % 8 == 0) ? 8 : ((k % 8 == 4) ? -8 : 0);
      4: return (k % 4 == 0 || k % 4 == 3) ? MINV : MAXV;
      default: return int'(32767.0 * $sin(2.0 * 3.14159265358979 * k / 64.0));
    endcase
  endfunction

  // One cycle: check this cycle's outputs, drive the next inputs, update model.
  task automatic step(input bit vld, input int smp, output bit acc);
    int v;
    @(negedge clk);
    cyc++;
    if (expq.size() > 0 && expq[0].due == cyc) begin
      v = int'($signed(out_data));
      check(out_valid === 1'b1 && v == expq[0].val, expq[0].tag, v, expq[0].val);
      if (track && v > peak) peak = v;
      last_out = v;
      void'(expq.pop_front());
    end else begin
      check(out_valid === 1'b0, "R4 (out_valid)", int'(out_valid), 0);
    end
    check(in_ready === !last_acc, "R2 (in_ready)", int'(in_ready), int'(!last_acc));
    in_valid = vld;
    // While not ready, offer junk that must be ignored (R2).
    in_data  = in_ready ? DW'(smp) : DW'(-12345);
    acc = vld && in_ready;
    if (acc) begin
      hist[3] = hist[2];
      hist[2] = hist[1];
      hist[1] = hist[0];
      hist[0] = smp;
      expq.push_back('{cyc + 2, model_even(), (seg_tag != "") ? seg_tag : "R5 (even)"});
      expq.push_back('{cyc + 3, hist[1], (seg_tag != "") ? seg_tag : "R7 (odd)"});
    end
    last_acc = acc;
  endtask

  task automatic run_seg(input string tag, input int mode, input int first, input int n, input int spacing);
    int  k = 0;
    int  c = 0;
    bit  a;
    seg_tag = tag;
    while (k < n) begin
      step((c % spacing) == 0, sample(mode, first + k), a);
      if (a) k++;
      c++;
    end
    seg_tag = "";
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) step(1'b0, 0, a);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) hist[i] = 0;
    repeat (3) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R1 (out_valid in reset)", int'(out_valid), 0);
      check(in_ready === 1'b1, "R1 (in_ready in reset)", int'(in_ready), 1);
    end
    rst_n = 1'b1;
    // R1: single sample after reset sees zero history.
    run_seg("R1 (zero history)", 0, 0, 1, 1);
    idle(4);
    // R8: constant with in_valid held high, exercising back-pressure (R2).
    run_seg("", 1, 0, 4, 1);
    run_seg("R8 (dc gain)", 1, 4, 12, 1);
    idle(3);
    check(last_out == 16384, "R8 (dc settled)", last_out, 16384);
    // R3/R4: sparse input with gaps.
    run_seg("R3 (sparse ramp)", 2, 0, 20, 3);
    run_seg("", 2, 20, 10, 5);
    idle(4);
    // R5: half-LSB ties.
    run_seg("R5 (rounding)", 3, 0, 16, 1);
    idle(4);
    // R6: overshoot in both directions.
    run_seg("R6 (saturation)", 4, 0, 16, 1);
    idle(4);
    // R8: slow full-scale sine; peak measured after settling.
    run_seg("", 5, 0, 128, 1);
    track = 1;
    run_seg("R8 (sine)", 5, 128, 128, 1);
    idle(4);
    track = 0;
    check(peak >= 32000, "R8 (sine peak)", peak, 32767);
    check(expq.size() == 0, "R3 (pending outputs)", expq.size(), 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule